// File: doc/BRIEF.md
# Shared-Interrupt Affinity Routing Table

This block keeps one 64-bit routing register for every shared interrupt of an interrupt controller. Software writes a processor affinity into the register through a 32-bit bus port. The block compares that affinity with a static table that holds the affinity of every core. It records which core, if any, the interrupt now targets. For every interrupt it drives a target core index with a valid flag, and it drives one target-bitmap bit for each (core, interrupt) pair. Delivery and pending logic sit outside the block and consume these outputs.

An affinity is three 8-bit levels: level 0 in bits 7:0, level 1 in bits 15:8 and level 2 in bits 23:16. Level 3 sits in the upper half of the register, and that half is not implemented. The block stores the written affinity so that a read returns what was written, even when no core matches. An interrupt whose affinity matches no core has no target at all.

Top module: `spi_route_table`

## Requirements
- R1: After reset every interrupt targets core 0. Its index is 0, its valid flag is 1, only core 0's bitmap bit is set for it, and a read of its register returns core 0's affinity.
- R2: A read request (bus_req=1, bus_we=0) is answered one cycle later. bus_rvalid is 1 in that cycle, and bus_rdata holds the stored affinity in bits 23:0 with bits 31:24 at zero.
- R3: An access with address bit 2 set targets the upper 32-bit half. Such a read returns zero and such a write changes nothing.
- R4: Interrupt s occupies byte offsets 0x100+8*s (lower half) and 0x104+8*s (upper half). An offset below 0x100, or at 0x100+8*NUM_SPI or above, reads zero and ignores writes.
- R5: A lower-half write whose bits 23:0 equal a core's affinity has a visible effect in the cycle after the write. From then on the interrupt's index is that core, its valid flag is 1, and its bitmap bit is set only for that core.
- R6: A lower-half write that matches no core sets the index to the not-allocated code 0xFF, clears the valid flag and leaves no bitmap bit set for that interrupt. A later read still returns bits 23:0 as written.
- R7: Bits 31:24 of written data take no part in the match and are not stored.
- R8: No interrupt ever has more than one bitmap bit set. When several cores share one affinity, the lowest-numbered core wins.
- R9: A write that retargets an interrupt clears the bitmap bit of the old core and sets the bit of the new core in the same update. Rewriting the current affinity leaves that core's bit set.
- R10: A write to one interrupt changes no other interrupt's index, valid flag or bitmap bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_aff | input | 24*NUM_CORES | Static affinity of each core; core c sits in bits 24c+23:24c |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the routing region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| tgt_idx | output | 8*NUM_SPI | Target core index of interrupt s in bits 8s+7:8s, 0xFF when none |
| tgt_vld | output | NUM_SPI | Interrupt s has a target core |
| tgt_map | output | NUM_CORES*NUM_SPI | Bit c*NUM_SPI+s is set when core c is the target of interrupt s |

## Verification
A single write can both remove an interrupt from its old core's bitmap and add it to the new core's bitmap, and the two may name the same core. The bench rewrites an interrupt with the affinity it already has, and it moves interrupts between cores that share an affinity value. It then compares the whole bitmap, index and valid vectors with a model that applies the clear before the set. Random writes use both matching and non-matching affinities with garbage in the top byte, and they are interleaved with upper-half and out-of-window accesses. After every access all interrupts are compared, so a disturbed neighbour is caught.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam int          AFF_W    = 24;
  localparam int          IDX_W    = 8;
  localparam logic [7:0]  NO_CORE  = 8'hFF;
  localparam int          WIN_BASE = 'h100;
endpackage

// File: rtl/spi_route_match.sv
// Parallel affinity comparator array with lowest-index priority.
module spi_route_match
  import spi_route_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic [NUM_CORES*AFF_W-1:0] core_aff,
  input  logic [AFF_W-1:0]           aff,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx,
  output logic [NUM_CORES-1:0]       onehot
);
  logic [NUM_CORES-1:0] eq;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
    assign eq[c] = (core_aff[c*AFF_W +: AFF_W] == aff);
  end

  always_comb begin
    hit    = 1'b0;
    idx    = NO_CORE;
    onehot = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (eq[c]) begin
        hit       = 1'b1;
        idx       = IDX_W'(c);
        onehot    = '0;
        onehot[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_route_decode.sv
// Routing window address decode.
module spi_route_decode
  import spi_route_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int NUM_SPI = 32,
  parameter int SPI_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic              hi_half,
  output logic [SPI_W-1:0]  spi
);
  localparam int WIN_END = WIN_BASE + 8 * NUM_SPI;

  logic [31:0]       a32;
  logic [ADDR_W-1:0] rel;

  assign a32     = 32'(addr);
  assign in_win  = (a32 >= 32'(WIN_BASE)) && (a32 < 32'(WIN_END));
  assign hi_half = addr[2];
  assign rel     = addr - ADDR_W'(WIN_BASE);
  assign spi     = rel[SPI_W+2:3];
endmodule

// File: rtl/spi_route_table.sv
// Per-interrupt affinity routing registers with target index and bitmap outputs.
module spi_route_table
  import spi_route_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int NUM_SPI   = 32,
  parameter int ADDR_W    = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CORES*AFF_W-1:0]   core_aff,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         bus_rvalid,
  output logic [NUM_SPI*IDX_W-1:0]     tgt_idx,
  output logic [NUM_SPI-1:0]           tgt_vld,
  output logic [NUM_CORES*NUM_SPI-1:0] tgt_map
);
  localparam int SPI_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;

  initial begin
    if (NUM_CORES > 255) $error("core index field holds at most 255 cores");
    if (ADDR_W < SPI_W + 3 || (1 << ADDR_W) < WIN_BASE + 8 * NUM_SPI)
      $error("ADDR_W too small for routing window");
  end

  logic [AFF_W-1:0]     aff_q [NUM_SPI];
  logic [IDX_W-1:0]     idx_q [NUM_SPI];
  logic [NUM_CORES-1:0] map_q [NUM_SPI];

  logic                 in_win, hi_half;
  logic [SPI_W-1:0]     spi;
  logic                 m_hit;
  logic [IDX_W-1:0]     m_idx;
  logic [NUM_CORES-1:0] m_onehot;
  logic                 wr_hit, rd_req;

  spi_route_decode #(.ADDR_W(ADDR_W), .NUM_SPI(NUM_SPI), .SPI_W(SPI_W)) u_dec (
    .addr(bus_addr), .in_win(in_win), .hi_half(hi_half), .spi(spi)
  );

  spi_route_match #(.NUM_CORES(NUM_CORES)) u_match (
    .core_aff(core_aff), .aff(bus_wdata[AFF_W-1:0]),
    .hit(m_hit), .idx(m_idx), .onehot(m_onehot)
  );

  assign wr_hit = bus_req && bus_we && in_win && !hi_half;
  assign rd_req = bus_req && !bus_we;

  // The stored affinity always matches the core whose bit is set, so
  // replacing the row clears the old core and sets the new one at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      for (int s = 0; s < NUM_SPI; s++) begin
        aff_q[s] <= core_aff[AFF_W-1:0];
        idx_q[s] <= '0;
        map_q[s] <= NUM_CORES'(1);
      end
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req)
        bus_rdata <= (in_win && !hi_half) ? {8'h00, aff_q[spi]} : 32'h0;
      if (wr_hit) begin
        aff_q[spi] <= bus_wdata[AFF_W-1:0];
        idx_q[spi] <= m_hit ? m_idx : NO_CORE;
        map_q[spi] <= m_onehot;
      end
    end
  end

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_out
    assign tgt_idx[s*IDX_W +: IDX_W] = idx_q[s];
    assign tgt_vld[s]                = (idx_q[s] != NO_CORE);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bit
      assign tgt_map[c*NUM_SPI + s] = map_q[s][c];
    end

    // R8: never two targets for one interrupt
    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(map_q[s]));
    // R6: valid flag agrees with the bitmap
    assert_vld_map_R6: assert property (@(posedge clk) disable iff (rst)
      tgt_vld[s] == (|map_q[s]));
  end

  // R2: read data only answers a read request of the previous cycle
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_req && !bus_we));
  // R3: upper half reads zero
  assert_hi_raz_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr[2])) |-> (bus_rdata == 32'h0));
  // R4: ignored writes leave every routing output unchanged
  assert_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !(in_win && !hi_half)) |=>
      ($stable(tgt_idx) && $stable(tgt_map)));
  // R7: top byte of read data is never stored
  assert_topbyte_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[31:24] == 8'h00));
endmodule

// File: tb/spi_route_table_tb.sv
module spi_route_table_tb;
  localparam int NC = 8;
  localparam int NS = 32;
  localparam int AW = 14;

  logic              clk = 1'b0;
  logic              rst;
  logic [NC*24-1:0]  core_aff;
  logic              bus_req, bus_we;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_rvalid;
  logic [NS*8-1:0]   tgt_idx;
  logic [NS-1:0]     tgt_vld;
  logic [NC*NS-1:0]  tgt_map;

  always #2 clk = ~clk;

  spi_route_table #(.NUM_CORES(NC), .NUM_SPI(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .core_aff(core_aff),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tgt_idx(tgt_idx), .tgt_vld(tgt_vld), .tgt_map(tgt_map)
  );

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic [23:0] m_aff [NS];
  logic [7:0]  m_idx [NS];

  // core 5 duplicates core 2 to exercise lowest-index priority
  function automatic logic [23:0] aff_of(int c);
    int k = (c == 5) ? 2 : c;
    return {8'(k >> 1), 8'(8'h20 + k), 8'(8'h40 + 3 * k)};
  endfunction

  function automatic logic [7:0] ref_match(logic [23:0] a);
    for (int c = 0; c < NC; c++) if (aff_of(c) == a) return 8'(c);
    return 8'hFF;
  endfunction

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_routes(string tag);
    logic [NS*8-1:0]  ei;
    logic [NS-1:0]    ev;
    logic [NC*NS-1:0] em;
    em = '0;
    for (int s = 0; s < NS; s++) begin
      ei[s*8 +: 8] = m_idx[s];
      ev[s] = (m_idx[s] != 8'hFF);
      for (int c = 0; c < NC; c++) em[c*NS + s] = (m_idx[s] == 8'(c));
    end
    chk({tag, " idx"}, 256'(tgt_idx), 256'(ei));
    chk({tag, " vld"}, 256'(tgt_vld), 256'(ev));
    chk({tag, " map"}, 256'(tgt_map), 256'(em));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (int'(a) >= 'h100 && int'(a) < 'h100 + 8 * NS && !a[2]) begin
      m_aff[(int'(a) - 'h100) / 8] = d[23:0];
      m_idx[(int'(a) - 'h100) / 8] = ref_match(d[23:0]);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    if (int'(a) >= 'h100 && int'(a) < 'h100 + 8 * NS && !a[2])
      e = {8'h00, m_aff[(int'(a) - 'h100) / 8]};
    else
      e = 32'h0;
    chk({tag, " rvalid"}, 256'(bus_rvalid), 256'(1));
    chk({tag, " rdata"}, 256'(bus_rdata), 256'(e));
  endtask

  function automatic logic [AW-1:0] lo_addr(int s);
    return AW'('h100 + 8 * s);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < NC; c++) core_aff[c*24 +: 24] = aff_of(c);
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < NS; s++) begin m_aff[s] = aff_of(0); m_idx[s] = 8'h00; end

    // R1 reset state
    chk_routes("R1 reset");
    chk("R2 rvalid idle", 256'(bus_rvalid), 256'(0));
    rd(lo_addr(7), "R1 reset read");
    rd(lo_addr(NS - 1), "R2 last spi read");

    // R5 directed retarget
    wr(lo_addr(3), {8'h00, aff_of(4)});
    chk_routes("R5 retarget");
    // R9 rewrite same affinity
    wr(lo_addr(3), {8'h00, aff_of(4)});
    chk_routes("R9 rewrite same");
    // R8 duplicate affinity: lowest index wins
    wr(lo_addr(9), {8'h00, aff_of(5)});
    chk_routes("R8 dup lowest");
    chk("R8 idx", 256'(tgt_idx[9*8 +: 8]), 256'(2));
    // R6 no match
    wr(lo_addr(10), 32'h00ABCDEF);
    chk_routes("R6 nomatch");
    rd(lo_addr(10), "R6 readback");
    // R7 top byte ignored
    wr(lo_addr(11), {8'hA5, aff_of(6)});
    chk_routes("R7 topbyte match");
    rd(lo_addr(11), "R7 readback");
    // R3 upper half
    wr(lo_addr(12) + 4, {8'h00, aff_of(7)});
    chk_routes("R3 hi write");
    rd(lo_addr(12) + 4, "R3 hi read");
    // R4 out of window
    wr(AW'('h0F8), {8'h00, aff_of(1)});
    chk_routes("R4 below window");
    wr(AW'('h100 + 8 * NS), {8'h00, aff_of(1)});
    chk_routes("R4 above window");
    rd(AW'('h0F8), "R4 below read");
    // R9 move from no target back to a core
    wr(lo_addr(10), {8'h00, aff_of(1)});
    chk_routes("R9 none to core");

    // random mix, R10 checked by full compare after each write
    for (int i = 0; i < 400; i++) begin
      int s = int'($urandom % NS);
      int k = int'($urandom % 8);
      logic [31:0] d;
      if (k < 4) begin
        d = {8'($urandom), aff_of(int'($urandom % NC))};
        wr(lo_addr(s), d);
        chk_routes("R10 rand match");
      end else if (k == 4) begin
        wr(lo_addr(s), $urandom);
        chk_routes("R6 rand value");
      end else if (k == 5) begin
        rd(lo_addr(s), "R2 rand read");
      end else if (k == 6) begin
        wr(lo_addr(s) + 4, {8'h00, aff_of(int'($urandom % NC))});
        chk_routes("R3 rand hi");
      end else begin
        wr(($urandom % 2) ? AW'($urandom % 'h100) : AW'('h100 + 8 * NS + ($urandom % 'h200)),
           {8'h00, aff_of(int'($urandom % NC))});
        chk_routes("R4 rand outside");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule